// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side control logic of a sector-erasable flash array. It watches write cycles on a synchronous address/data bus and recognises command sequences that begin with a two-write unlock prefix at fixed key addresses. Three operations are recognised: word program, sector erase and whole-array erase. The array is a small synthesizable memory split into equal sectors. Program and erase times come from parameterised cycle counters.

While an operation runs, the block pulls its ready output low. Reads that hit the busy region return a status word instead of data. In that word, bit 7 is the complement of the bit 7 being written, and bit 6 flips on every such read, so software can poll for completion. During a sector erase, the rest of the array stays readable and programmable. An asynchronous reset aborts any operation and returns the decoder to read mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Reset is active-low and asynchronous. It returns the decoder to read mode, ends any running operation with rdy high, clears the status toggle to 0, and leaves the array contents unchanged.
- R2: A program is four writes: AAh at key address A (low 16 address bits 5555h), 55h at key address B (low 16 bits 2AAAh), A0h at key address A, then the target address with its data. Commands are matched on data bits 7:0 only. When the operation ends, the word holds the AND of its old value and the new data.
- R3: An erase is six writes: AAh@A, 55h@B, 80h@A, AAh@A, 55h@B. The sixth write is either 30h at any address (this erases the sector that address selects) or 10h at key address A (this erases the whole array). After the erase, every word of the selected sectors reads FFFFh.
- R4: A write that does not match the expected next step returns the decoder to read mode. That write does not begin a new sequence and does not change the array.
- R5: rdy goes low at the clock edge that accepts the final write of a command. It stays low for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R6: Read data appears on rdata one cycle after rd_en. A status read returns a word that is zero except for two bits. Bit 7 is the complement of the programmed data bit 7, or 0 during an erase. Bit 6 is the toggle, which inverts on each status read. Every read during a program is a status read.
- R7: During a sector erase, reads to other sectors return array data. A program sequence that targets another sector is applied at its final write, and rdy stays low.
- R8: While a program is busy, all writes are ignored. While an erase is busy, further erase commands are ignored.
- R9: A word is selected by the top log2(SECT_N) address bits (the sector) together with the low log2(SECT_WORDS) bits. The address bits between them do not affect which word is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data or status word |
| rdy | output | 1 | High when idle, low while an operation runs |

## Verification
The bench uses the default configuration: 21 address bits, 16-bit data, 32 sectors of 4 words, an 8-cycle program and a 64-cycle erase. With only 128 words, every word can be programmed and swept after each operation. The 64-cycle erase window is long enough to fit reads, a complete program sequence and a rejected erase inside one sector erase. The short program time lets each busy length be counted exactly.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   typedef enum logic [2:0] {
      SQ_READ, SQ_U1, SQ_U2, SQ_PGM, SQ_E80, SQ_EU1, SQ_EU2
   } seq_state_t;

   typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_t;

   localparam logic [15:0] KEY_ADDR_A = 16'h5555;
   localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
   localparam logic [7:0]  CD_UNLOCK1 = 8'hAA;
   localparam logic [7:0]  CD_UNLOCK2 = 8'h55;
   localparam logic [7:0]  CD_PROG    = 8'hA0;
   localparam logic [7:0]  CD_ERASE   = 8'h80;
   localparam logic [7:0]  CD_SECT    = 8'h30;
   localparam logic [7:0]  CD_CHIP    = 8'h10;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
   import fcd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hold,
   input  logic        wr_en,
   input  logic [15:0] key_addr,
   input  logic [7:0]  cmd,
   output logic        go_prog,
   output logic        go_sect,
   output logic        go_chip
);
   seq_state_t st, nxt;
   logic at_a, at_b;

   assign at_a = (key_addr == KEY_ADDR_A);
   assign at_b = (key_addr == KEY_ADDR_B);

   always_comb begin
      nxt     = st;
      go_prog = 1'b0;
      go_sect = 1'b0;
      go_chip = 1'b0;
      if (wr_en) begin
         nxt = SQ_READ;
         unique case (st)
            SQ_READ: if (at_a && cmd == CD_UNLOCK1) nxt = SQ_U1;
            SQ_U1:   if (at_b && cmd == CD_UNLOCK2) nxt = SQ_U2;
            SQ_U2: begin
               if (at_a && cmd == CD_PROG)       nxt = SQ_PGM;
               else if (at_a && cmd == CD_ERASE) nxt = SQ_E80;
            end
            SQ_PGM:  go_prog = 1'b1;
            SQ_E80:  if (at_a && cmd == CD_UNLOCK1) nxt = SQ_EU1;
            SQ_EU1:  if (at_b && cmd == CD_UNLOCK2) nxt = SQ_EU2;
            SQ_EU2: begin
               if (cmd == CD_SECT)               go_sect = 1'b1;
               else if (at_a && cmd == CD_CHIP)  go_chip = 1'b1;
            end
            default: nxt = SQ_READ;
         endcase
      end
      if (hold) begin
         nxt     = SQ_READ;
         go_prog = 1'b0;
         go_sect = 1'b0;
         go_chip = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SQ_READ;
      else        st <= nxt;
   end

   // R2 R3: at most one command issues per write
   a_r3_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({go_prog, go_sect, go_chip}));

   // R8: a held decoder sits in read mode
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (st == SQ_READ));
endmodule

// File: rtl/fcd_timer.sv
module fcd_timer #(
   parameter int PROG_CYC  = 8,
   parameter int ERASE_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_prog,
   input  logic start_erase,
   output logic busy,
   output logic done
);
   localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_len
         $error("busy durations must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (start_prog)       cnt <= CW'(PROG_CYC);
      else if (start_erase)      cnt <= CW'(ERASE_CYC);
      else if (cnt != '0)        cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

   // R5: the last busy cycle is followed by idle
   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_prog && !start_erase) |=> !busy);
endmodule

// File: rtl/fcd_array.sv
module fcd_array #(
   parameter int DATA_W     = 16,
   parameter int SECT_N     = 32,
   parameter int SECT_WORDS = 4
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        pgm_en,
   input  logic [$clog2(SECT_N)+$clog2(SECT_WORDS)-1:0] pgm_idx,
   input  logic [DATA_W-1:0]                           pgm_data,
   input  logic                                        ers_en,
   input  logic [SECT_N-1:0]                           ers_mask,
   input  logic [$clog2(SECT_N)+$clog2(SECT_WORDS)-1:0] rd_idx,
   output logic [DATA_W-1:0]                           rd_data
);
   localparam int SECT_W = $clog2(SECT_N);
   localparam int OFF_W  = $clog2(SECT_WORDS);
   localparam int DEPTH  = SECT_N * SECT_WORDS;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (ers_en) begin
         for (int s = 0; s < SECT_N; s++) begin
            if (ers_mask[s]) begin
               for (int w = 0; w < SECT_WORDS; w++)
                  mem[{s[SECT_W-1:0], w[OFF_W-1:0]}] <= '1;
            end
         end
      end
      if (pgm_en) mem[pgm_idx] <= mem[pgm_idx] & pgm_data;
   end

   assign rd_data = mem[rd_idx];

   // R2: programming never sets a bit
   a_r2_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_en && !ers_en) |=>
         ((mem[$past(pgm_idx)] & ~$past(mem[pgm_idx])) == '0));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fcd_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int DATA_W     = 16,
   parameter int SECT_N     = 32,
   parameter int SECT_WORDS = 4,
   parameter int PROG_CYC   = 8,
   parameter int ERASE_CYC  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdy
);
   localparam int SECT_W = $clog2(SECT_N);
   localparam int OFF_W  = $clog2(SECT_WORDS);
   localparam int IDX_W  = SECT_W + OFF_W;

   generate
      if (ADDR_W < 16) begin : g_bad_aw
         $error("ADDR_W must cover the 16-bit key addresses");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("DATA_W must cover an 8-bit command");
      end
      if ((1 << SECT_W) != SECT_N || SECT_N < 2) begin : g_bad_sn
         $error("SECT_N must be a power of two, at least 2");
      end
      if ((1 << OFF_W) != SECT_WORDS || SECT_WORDS < 2) begin : g_bad_sw
         $error("SECT_WORDS must be a power of two, at least 2");
      end
      if (ADDR_W < IDX_W) begin : g_bad_map
         $error("ADDR_W too small for the array");
      end
   endgenerate

   logic [SECT_W-1:0] a_sect;
   logic [IDX_W-1:0]  a_idx;
   assign a_sect = addr[ADDR_W-1 -: SECT_W];
   assign a_idx  = {a_sect, addr[OFF_W-1:0]};

   op_t               op_q;
   logic [DATA_W-1:0] pd_q;
   logic [IDX_W-1:0]  pidx_q;
   logic [SECT_N-1:0] emask_q;
   logic              tog_q;

   logic busy, done, prog_busy, erase_busy;
   logic go_prog, go_sect, go_chip;
   logic start_prog, start_erase, quick_prog;
   logic pgm_en, ers_en, stat_sel;
   logic [IDX_W-1:0]  pgm_idx;
   logic [DATA_W-1:0] pgm_data, arr_rd, stat_word;
   logic [SECT_N-1:0] new_mask;

   assign prog_busy  = busy && (op_q == OP_PROG);
   assign erase_busy = busy && (op_q == OP_ERASE);

   fcd_seq u_seq (
      .clk(clk), .rst_n(rst_n), .hold(prog_busy), .wr_en(wr_en),
      .key_addr(addr[15:0]), .cmd(wdata[7:0]),
      .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip)
   );

   assign start_prog  = go_prog && !busy;
   assign start_erase = (go_sect || go_chip) && !busy;
   assign quick_prog  = go_prog && erase_busy && !emask_q[a_sect];
   assign new_mask    = go_chip ? '1 : (SECT_N'(1) << a_sect);

   fcd_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog),
      .start_erase(start_erase), .busy(busy), .done(done)
   );

   assign pgm_en   = quick_prog || (done && op_q == OP_PROG);
   assign pgm_idx  = quick_prog ? a_idx : pidx_q;
   assign pgm_data = quick_prog ? wdata : pd_q;
   assign ers_en   = done && (op_q == OP_ERASE);

   fcd_array #(.DATA_W(DATA_W), .SECT_N(SECT_N), .SECT_WORDS(SECT_WORDS)) u_array (
      .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .pgm_idx(pgm_idx),
      .pgm_data(pgm_data), .ers_en(ers_en), .ers_mask(emask_q),
      .rd_idx(a_idx), .rd_data(arr_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_NONE;
         pd_q    <= '0;
         pidx_q  <= '0;
         emask_q <= '0;
      end else if (start_prog) begin
         op_q    <= OP_PROG;
         pd_q    <= wdata;
         pidx_q  <= a_idx;
      end else if (start_erase) begin
         op_q    <= OP_ERASE;
         emask_q <= new_mask;
      end
   end

   assign stat_sel = prog_busy || (erase_busy && emask_q[a_sect]);

   always_comb begin
      stat_word    = '0;
      stat_word[7] = (op_q == OP_PROG) ? ~pd_q[7] : 1'b0;
      stat_word[6] = ~tog_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         tog_q <= 1'b0;
      end else if (rd_en) begin
         rdata <= stat_sel ? stat_word : arr_rd;
         if (stat_sel) tog_q <= ~tog_q;
      end
   end

   assign rdy = !busy;

   // R5: an accepted command drops ready on the next cycle
   a_r5_rdy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (start_prog || start_erase) |=> !rdy);

   // R6: each status read inverts the toggle
   a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && stat_sel) |=> (tog_q != $past(tog_q)));

   // R7: reads outside the erasing sectors return array data
   a_r7_data_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && erase_busy && !emask_q[a_sect]) |=> (rdata == $past(arr_rd)));

   // R8: no array write while a program is still counting
   a_r8_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && !done) |-> !pgm_en);
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
   localparam int PROG_CYC  = 8;
   localparam int ERASE_CYC = 64;
   localparam logic [20:0] KA = 21'h05555;
   localparam logic [20:0] KB = 21'h02AAA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [20:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        rdy;

   int nchk = 0, nerr = 0;
   bit ended = 0;
   logic [15:0] model [128];
   logic tog = 1'b0;

   always #4 clk = ~clk;

   flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdy(rdy)
   );

   function automatic logic [20:0] wa(input logic [6:0] idx, input logic [13:0] salt);
      return {idx[6:2], salt, idx[1:0]};
   endfunction

   function automatic logic [15:0] pat(input int i);
      return 16'(i * 40503) ^ 16'h5AC3;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [20:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [20:0] a, output logic [15:0] v);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; v = rdata;
   endtask

   task automatic prog(input logic [20:0] a, input logic [15:0] d);
      wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h00A0); wr(a, d);
   endtask

   task automatic erase(input logic [20:0] a, input logic [15:0] d);
      wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0080);
      wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(a, d);
   endtask

   task automatic wait_rdy(output int n);
      n = 0;
      while (!rdy && n < 10000) begin n++; @(negedge clk); end
   endtask

   function automatic logic [15:0] stat(input logic b7);
      tog = ~tog;
      return {8'h00, b7, tog, 6'h00};
   endfunction

   task automatic sweep(input string tag, input logic [13:0] salt);
      logic [15:0] v;
      for (int i = 0; i < 128; i++) begin
         rd(wa(7'(i), salt ^ 14'(i * 37)), v);
         chk(tag, v, model[i]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 ready after reset", {15'b0, rdy}, 16'h1);

      // R3 whole-array erase, exact busy length (R5)
      erase(KA, 16'h0010);
      wait_rdy(n);
      chk("R5 erase busy length", 16'(n), 16'(ERASE_CYC));
      for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
      sweep("R3 chip erase", 14'h0123);

      // R6 status during erase
      erase(KA, 16'h0010);
      rd(wa(7'd3, 14'h0), v); chk("R6 erase status first", v, stat(1'b0));
      rd(wa(7'd90, 14'h1), v); chk("R6 erase status second", v, stat(1'b0));
      wait_rdy(n);

      // R2 program every word, R5 length, R6 status polarity
      for (int i = 0; i < 128; i++) begin
         logic [15:0] d;
         d = pat(i);
         prog(wa(7'(i), 14'(i * 113)), d);
         if (i % 16 == 3) begin
            rd(wa(7'(i ^ 5), 14'h2A), v);
            chk("R6 program status", v, stat(~d[7]));
            wait_rdy(n);
         end else begin
            wait_rdy(n);
            chk("R5 program busy length", 16'(n), 16'(PROG_CYC));
         end
         model[i] = model[i] & d;
      end
      sweep("R2 R9 programmed data", 14'h3FFF);

      // R2 second program ANDs into sector 2
      for (int i = 8; i < 12; i++) begin
         logic [15:0] d;
         d = ~(16'h1 << (i % 16)) & 16'hF0FF;
         prog(wa(7'(i), 14'h0777), d);
         wait_rdy(n);
         model[i] = model[i] & d;
         rd(wa(7'(i), 14'h1111), v); chk("R2 AND of old and new", v, model[i]);
      end

      // R4 broken unlock then would-be program
      wr(KA, 16'h00AA); wr(KB, 16'h0056); wr(KA, 16'h00A0); wr(wa(7'd10, 14'h5), 16'h0000);
      chk("R4 no busy after broken seq", {15'b0, rdy}, 16'h1);
      rd(wa(7'd10, 14'h9), v); chk("R4 word unchanged", v, model[10]);
      // R4 erase with chip code at wrong address
      erase(21'h01234, 16'h0010);
      chk("R4 no erase at wrong address", {15'b0, rdy}, 16'h1);
      rd(wa(7'd0, 14'h0), v); chk("R4 word 0 unchanged", v, model[0]);
      // R4 recovery: a valid program works afterwards
      prog(wa(7'd11, 14'h0), 16'h0F0F); wait_rdy(n);
      model[11] = model[11] & 16'h0F0F;
      rd(wa(7'd11, 14'h2), v); chk("R4 recovery program", v, model[11]);

      // R7 R8 sector erase of sector 5
      erase(wa(7'd21, 14'h2222), 16'h0030);
      rd(wa(7'd24, 14'h0), v); chk("R7 read other sector", v, model[24]);
      rd(wa(7'd22, 14'h0), v); chk("R7 read erasing sector status", v, stat(1'b0));
      prog(wa(7'd28, 14'h0333), 16'h00FF);
      model[28] = model[28] & 16'h00FF;
      rd(wa(7'd28, 14'h0), v); chk("R7 program during erase", v, model[28]);
      chk("R7 still busy", {15'b0, rdy}, 16'h0);
      erase(wa(7'd36, 14'h0), 16'h0030);
      wait_rdy(n);
      for (int i = 20; i < 24; i++) model[i] = 16'hFFFF;
      sweep("R3 R8 after sector erase", 14'h0AAA);

      // R8 writes ignored during program busy
      prog(wa(7'd40, 14'h0), 16'h0000);
      prog(wa(7'd41, 14'h0), 16'h0000);
      wait_rdy(n);
      model[40] = 16'h0000;
      rd(wa(7'd40, 14'h0), v); chk("R8 first program applied", v, model[40]);
      rd(wa(7'd41, 14'h0), v); chk("R8 held program dropped", v, model[41]);

      // R1 reset aborts a sector erase
      erase(wa(7'd48, 14'h0), 16'h0030);
      repeat (5) @(negedge clk);
      rd(wa(7'd49, 14'h0), v); chk("R6 status before reset", v, stat(1'b0));
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      tog = 1'b0;
      chk("R1 ready after abort", {15'b0, rdy}, 16'h1);
      rd(wa(7'd49, 14'h0), v); chk("R1 array kept after abort", v, model[49]);
      erase(KA, 16'h0010);
      rd(wa(7'd1, 14'h0), v); chk("R1 toggle restarts", v, 16'h0040);
      wait_rdy(n);
      for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
      sweep("R3 final chip erase", 14'h1357);

      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule